// File: doc/BRIEF.md
# Hysteretic Two-Stage Receive Gain Controller

This block closes the digital side of a receiver's automatic gain loop. A flash converter presents a 7-bit signal-strength level with 80 meaningful values. At a paced update instant the controller compares that level against a high and a low threshold. It moves a combined gain setting one step down when the signal is too strong, and one step up when it is too weak. It does not move when the level sits between the thresholds. The combined setting drives two analog stages: a 2-bit front-end amplifier gain and a filter gain with three legal levels.

The update instants come from a programmable divider, so the analog loop can settle between steps. The recommended divider value of 33 gives roughly a 3 kHz update rate. Software loads the thresholds, the divider, the loop enable and a manual gain pair through one write strobe. A receive-entry pulse restores the default thresholds and re-enables the loop. When the loop is disabled, the manual fields drive the gain pins directly. The strength level is a continuously presented converter output, not a stream, so every pin of this block is a plain control or status pin with no valid/ready handshake. A readback register tracks the latest clamped strength level.

Top module: `agc_ctrl`

## Requirements
- R1: The strength input is clamped to 79 when it exceeds 79. `rssi_rb` shows the clamped value of the input one clock after it is sampled, and it is 0 after reset.
- R2: On an update tick with the loop enabled, a clamped strength strictly above the high threshold lowers the gain index by one at the next clock edge.
- R3: On an update tick with the loop enabled, a clamped strength strictly below the low threshold raises the gain index by one at the next clock edge.
- R4: A strength level within [low, high] on a tick leaves the gain unchanged. The gain never changes on a cycle without a tick.
- R5: The gain index runs from 0 to 11. It maps to `lna_gain` = index / 3 and `flt_gain` = index mod 3, so filter steps are taken before the amplifier changes. For example, raising from lna 0 / flt 2 gives lna 1 / flt 0.
- R6: The gain index saturates at 0 and at 11 without wraparound.
- R7: `upd_tick` is high for one cycle every div+1 cycles, where div is the loaded 6-bit divider value. The first tick comes div cycles after a write or receive entry. A divider of 0 ticks on every cycle.
- R8: After reset, the high threshold is 70, the low threshold is 30, the divider is 33, the loop is enabled and the gain index is 11 (lna 3, flt 2). A `rx_start` pulse restores the thresholds, the enable and the index 11, restarts the divider, and keeps the divider value.
- R9: With the loop disabled, `lna_gain` and `flt_gain` equal the written manual fields. A manual filter value of 3 is clamped to 2. The ladder index is held and resumes when the loop is re-enabled.
- R10: `cfg_err` is high whenever the high threshold minus the low threshold is 30 or less. This includes a high threshold below the low one.
- R11: A cycle with `cfg_wr` or `rx_start` high takes no gain step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Receive-entry pulse, restores loop defaults |
| cfg_wr | input | 1 | Loads all cfg_* fields |
| cfg_hi_thr | input | 7 | High strength threshold |
| cfg_lo_thr | input | 7 | Low strength threshold |
| cfg_div | input | 6 | Update divider value |
| cfg_agc_en | input | 1 | Loop enable (0 selects manual gain) |
| cfg_lna_gain | input | 2 | Manual amplifier gain |
| cfg_flt_gain | input | 2 | Manual filter gain (3 clamps to 2) |
| rssi_code | input | 7 | Strength level from the converter |
| lna_gain | output | 2 | Amplifier gain code |
| flt_gain | output | 2 | Filter gain code, 0 to 2 |
| rssi_rb | output | 7 | Latest clamped strength level |
| upd_tick | output | 1 | Update instant strobe |
| cfg_err | output | 1 | Threshold span too small |

## Verification
The assertions check several properties on every cycle. The gain index moves by at most one step, it never moves without an enabled tick, and it stays pinned at its limits. A non-zero divider never gives two ticks in a row. The readback never exceeds 79, and the filter code never reaches 3. Other behaviours only the bench scenarios can show. These are the direction of each step against the thresholds, the filter-first ordering of the ladder, the exact tick spacing for different divider values, the defaults restored by receive entry, the manual override with its clamped filter field, and the threshold-span error flag.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int RSSI_W_DEF    = 7;
  localparam int RSSI_MAX_DEF  = 79;
  localparam int LNA_W_DEF     = 2;
  localparam int FLT_W_DEF     = 2;
  localparam int FLT_LVL_DEF   = 3;
  localparam int DIV_W_DEF     = 6;
  localparam int HI_THR_DEF    = 70;
  localparam int LO_THR_DEF    = 30;
  localparam int DIV_VAL_DEF   = 33;
  localparam int MIN_SPAN_DEF  = 30;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/agc_tick_div.sv
module agc_tick_div #(
  parameter int DIV_W = agc_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div != '0) |=> !tick); // R7
endmodule

// File: rtl/agc_step_decide.sv
module agc_step_decide #(
  parameter int RSSI_W   = agc_pkg::RSSI_W_DEF,
  parameter int RSSI_MAX = agc_pkg::RSSI_MAX_DEF
) (
  input  logic [RSSI_W-1:0] rssi_in,
  input  logic [RSSI_W-1:0] hi_thr,
  input  logic [RSSI_W-1:0] lo_thr,
  output logic [RSSI_W-1:0] rssi_clamped,
  output agc_pkg::step_e    step
);
  localparam logic [RSSI_W-1:0] TOP = RSSI_W'(RSSI_MAX);

  always_comb begin
    rssi_clamped = (rssi_in > TOP) ? TOP : rssi_in;
    if (rssi_clamped > hi_thr)      step = agc_pkg::STEP_DOWN;
    else if (rssi_clamped < lo_thr) step = agc_pkg::STEP_UP;
    else                            step = agc_pkg::STEP_HOLD;
  end
endmodule

// File: rtl/agc_ladder.sv
module agc_ladder #(
  parameter int LNA_W   = agc_pkg::LNA_W_DEF,
  parameter int FLT_W   = agc_pkg::FLT_W_DEF,
  parameter int FLT_LVL = agc_pkg::FLT_LVL_DEF,
  localparam int STEPS  = (1 << LNA_W) * FLT_LVL,
  localparam int IDX_W  = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             step_en,
  input  agc_pkg::step_e   step,
  output logic [IDX_W-1:0] idx,
  output logic [LNA_W-1:0] lna,
  output logic [FLT_W-1:0] flt
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(STEPS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (step_en) begin
      unique case (step)
        agc_pkg::STEP_UP:   if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
        agc_pkg::STEP_DOWN: if (idx_q != '0)      idx_d = idx_q - 1'b1;
        default:            idx_d = idx_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= IDX_MAX;
    else if (preset) idx_q <= IDX_MAX;
    else             idx_q <= idx_d;
  end

  assign idx = idx_q;
  assign lna = LNA_W'(idx_q / FLT_LVL);
  assign flt = FLT_W'(idx_q % FLT_LVL);

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !preset |=> (idx == $past(idx) || idx == $past(idx) + 1 || idx == $past(idx) - 1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && !step_en) |=> $stable(idx)); // R4
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && idx == IDX_MAX && step == agc_pkg::STEP_UP) |=> idx == IDX_MAX); // R6
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && idx == '0 && step == agc_pkg::STEP_DOWN) |=> idx == '0); // R6
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl #(
  parameter int RSSI_W   = agc_pkg::RSSI_W_DEF,
  parameter int RSSI_MAX = agc_pkg::RSSI_MAX_DEF,
  parameter int LNA_W    = agc_pkg::LNA_W_DEF,
  parameter int FLT_W    = agc_pkg::FLT_W_DEF,
  parameter int FLT_LVL  = agc_pkg::FLT_LVL_DEF,
  parameter int DIV_W    = agc_pkg::DIV_W_DEF,
  parameter int HI_DEF   = agc_pkg::HI_THR_DEF,
  parameter int LO_DEF   = agc_pkg::LO_THR_DEF,
  parameter int DIV_DEF  = agc_pkg::DIV_VAL_DEF,
  parameter int MIN_SPAN = agc_pkg::MIN_SPAN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_start,
  input  logic              cfg_wr,
  input  logic [RSSI_W-1:0] cfg_hi_thr,
  input  logic [RSSI_W-1:0] cfg_lo_thr,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_agc_en,
  input  logic [LNA_W-1:0]  cfg_lna_gain,
  input  logic [FLT_W-1:0]  cfg_flt_gain,
  input  logic [RSSI_W-1:0] rssi_code,
  output logic [LNA_W-1:0]  lna_gain,
  output logic [FLT_W-1:0]  flt_gain,
  output logic [RSSI_W-1:0] rssi_rb,
  output logic              upd_tick,
  output logic              cfg_err
);
  localparam int STEPS = (1 << LNA_W) * FLT_LVL;
  localparam int IDX_W = $clog2(STEPS);
  localparam int SPAN_W = RSSI_W + 2;
  localparam logic [FLT_W-1:0] FLT_TOP = FLT_W'(FLT_LVL - 1);

  logic [RSSI_W-1:0] hi_q, lo_q, rb_q, rssi_cl;
  logic [DIV_W-1:0]  div_q;
  logic              en_q;
  logic [LNA_W-1:0]  man_lna_q, lad_lna;
  logic [FLT_W-1:0]  man_flt_q, lad_flt;
  logic [IDX_W-1:0]  lad_idx;
  logic              tick, restart, step_en;
  agc_pkg::step_e    step;
  logic signed [SPAN_W-1:0] span;

  assign restart = cfg_wr | rx_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= RSSI_W'(HI_DEF);
      lo_q      <= RSSI_W'(LO_DEF);
      div_q     <= DIV_W'(DIV_DEF);
      en_q      <= 1'b1;
      man_lna_q <= '0;
      man_flt_q <= '0;
    end else if (rx_start) begin
      hi_q <= RSSI_W'(HI_DEF);
      lo_q <= RSSI_W'(LO_DEF);
      en_q <= 1'b1;
    end else if (cfg_wr) begin
      hi_q      <= cfg_hi_thr;
      lo_q      <= cfg_lo_thr;
      div_q     <= cfg_div;
      en_q      <= cfg_agc_en;
      man_lna_q <= cfg_lna_gain;
      man_flt_q <= (cfg_flt_gain > FLT_TOP) ? FLT_TOP : cfg_flt_gain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_q <= '0;
    else        rb_q <= rssi_cl;
  end

  agc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(div_q), .tick(tick)
  );

  agc_step_decide #(.RSSI_W(RSSI_W), .RSSI_MAX(RSSI_MAX)) u_dec (
    .rssi_in(rssi_code), .hi_thr(hi_q), .lo_thr(lo_q),
    .rssi_clamped(rssi_cl), .step(step)
  );

  assign step_en = tick & en_q & ~restart;

  agc_ladder #(.LNA_W(LNA_W), .FLT_W(FLT_W), .FLT_LVL(FLT_LVL)) u_lad (
    .clk(clk), .rst_n(rst_n), .preset(rx_start), .step_en(step_en),
    .step(step), .idx(lad_idx), .lna(lad_lna), .flt(lad_flt)
  );

  assign span     = $signed({2'b00, hi_q}) - $signed({2'b00, lo_q});
  assign cfg_err  = (span <= $signed(SPAN_W'(MIN_SPAN)));
  assign lna_gain = en_q ? lad_lna : man_lna_q;
  assign flt_gain = en_q ? lad_flt : man_flt_q;
  assign rssi_rb  = rb_q;
  assign upd_tick = tick;

  AST_RB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_rb <= RSSI_W'(RSSI_MAX)); // R1
  AST_FLT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    flt_gain <= FLT_TOP); // R9
  AST_NO_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !rx_start) |=> $stable(lad_idx)); // R11
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lad_idx <= IDX_W'(STEPS - 1)); // R6
endmodule

// File: tb/agc_ctrl_test.sv
module agc_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 1'b0, cfg_wr = 1'b0, cfg_agc_en = 1'b1;
  logic [6:0] cfg_hi_thr = '0, cfg_lo_thr = '0, rssi_code = '0;
  logic [5:0] cfg_div = '0;
  logic [1:0] cfg_lna_gain = '0, cfg_flt_gain = '0;
  logic [1:0] lna_gain, flt_gain;
  logic [6:0] rssi_rb;
  logic upd_tick, cfg_err;

  int checks = 0, fails = 0;
  int m_hi, m_lo, m_div, m_en, m_mlna, m_mflt, m_idx, m_cnt, m_rb;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .cfg_wr(cfg_wr),
    .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_div(cfg_div),
    .cfg_agc_en(cfg_agc_en), .cfg_lna_gain(cfg_lna_gain),
    .cfg_flt_gain(cfg_flt_gain), .rssi_code(rssi_code),
    .lna_gain(lna_gain), .flt_gain(flt_gain), .rssi_rb(rssi_rb),
    .upd_tick(upd_tick), .cfg_err(cfg_err)
  );

  function automatic int clamp79(int v);
    return (v > 79) ? 79 : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model state (called away from the edge).
  task automatic compare();
    int el, ef;
    el = m_en ? m_idx / 3 : m_mlna;
    ef = m_en ? m_idx % 3 : m_mflt;
    chk({m_tag, " lna_gain"}, int'(lna_gain), el);
    chk({m_tag, " flt_gain"}, int'(flt_gain), ef);
    chk("R1 rssi_rb", int'(rssi_rb), m_rb);
    chk("R7 upd_tick", int'(upd_tick), (m_cnt == m_div) ? 1 : 0);
    chk("R10 cfg_err", int'(cfg_err), ((m_hi - m_lo) <= 30) ? 1 : 0);
  endtask

  // Model of one clock edge, derived from the requirements.
  task automatic model_edge();
    int r, tk;
    r = clamp79(int'(rssi_code));
    if (!rst_n) begin
      m_hi = 70; m_lo = 30; m_div = 33; m_en = 1; m_idx = 11; m_cnt = 0;
      m_mlna = 0; m_mflt = 0; m_rb = 0; m_tag = "R8";
      return;
    end
    m_rb = r;
    if (rx_start) begin
      m_hi = 70; m_lo = 30; m_en = 1; m_idx = 11; m_cnt = 0; m_tag = "R8";
    end else if (cfg_wr) begin
      m_hi = cfg_hi_thr; m_lo = cfg_lo_thr; m_div = cfg_div; m_en = cfg_agc_en;
      m_mlna = cfg_lna_gain; m_mflt = (cfg_flt_gain > 2) ? 2 : cfg_flt_gain;
      m_cnt = 0; m_tag = m_en ? "R11" : "R9";
    end else begin
      tk = (m_cnt == m_div);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (!m_en) m_tag = "R9";
      else if (!tk) m_tag = "R4";
      else if (r > m_hi) begin
        if (m_idx == 0) m_tag = "R6"; else begin m_idx--; m_tag = "R2"; end
      end else if (r < m_lo) begin
        if (m_idx == 11) m_tag = "R6"; else begin m_idx++; m_tag = "R3"; end
      end else m_tag = "R4";
    end
  endtask

  task automatic cyc();
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic write_cfg(int hi, int lo, int dv, int en, int ml, int mf);
    cfg_hi_thr = 7'(hi); cfg_lo_thr = 7'(lo); cfg_div = 6'(dv);
    cfg_agc_en = en[0]; cfg_lna_gain = 2'(ml); cfg_flt_gain = 2'(mf);
    cfg_wr = 1'b1;
    cyc();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    rssi_code = 7'd50;
    model_edge();
    repeat (2) cyc();
    rst_n = 1'b1;
    // R8: reset state
    chk("R8 reset lna", int'(lna_gain), 3);
    chk("R8 reset flt", int'(flt_gain), 2);
    chk("R8 reset cfg_err", int'(cfg_err), 0);
    chk("R8 reset rssi_rb", int'(rssi_rb), 0);

    // R2/R6: strong signal drives gain to the bottom at default pacing
    rssi_code = 7'd120;
    repeat (14 * 34) cyc();
    chk("R6 bottom lna", int'(lna_gain), 0);
    chk("R6 bottom flt", int'(flt_gain), 0);
    chk("R1 clamp readback", int'(rssi_rb), 79);

    // R5: filter steps first, then amplifier; divider 0 ticks every cycle
    write_cfg(70, 30, 0, 1, 0, 0);
    rssi_code = 7'd5;
    repeat (2) cyc();
    chk("R5 ladder lna at idx2", int'(lna_gain), 0);
    chk("R5 ladder flt at idx2", int'(flt_gain), 2);
    cyc();
    chk("R5 ladder lna at idx3", int'(lna_gain), 1);
    chk("R5 ladder flt at idx3", int'(flt_gain), 0);
    repeat (12) cyc();
    chk("R6 top lna", int'(lna_gain), 3);
    chk("R6 top flt", int'(flt_gain), 2);

    // R7: divider 2 with a ramped strength input
    write_cfg(70, 30, 2, 1, 0, 0);
    for (int i = 0; i < 128; i++) begin
      rssi_code = 7'(i);
      cyc();
    end
    for (int i = 127; i >= 0; i--) begin
      rssi_code = 7'(i);
      cyc();
    end

    // R10: threshold span corners
    write_cfg(60, 30, 1, 1, 0, 0);
    chk("R10 span 30", int'(cfg_err), 1);
    write_cfg(61, 30, 1, 1, 0, 0);
    chk("R10 span 31", int'(cfg_err), 0);
    write_cfg(20, 40, 1, 1, 0, 0);
    chk("R10 inverted", int'(cfg_err), 1);

    // R9: manual override, filter field 3 clamps to 2, ladder held
    write_cfg(75, 10, 0, 0, 2, 3);
    chk("R9 manual lna", int'(lna_gain), 2);
    chk("R9 manual flt clamp", int'(flt_gain), 2);
    rssi_code = 7'd127;
    repeat (20) cyc();
    chk("R9 manual held lna", int'(lna_gain), 2);

    // Random stimulus with assorted configurations
    for (int blk = 0; blk < 6; blk++) begin
      int hi, lo, dv;
      lo = $urandom_range(0, 45);
      hi = lo + $urandom_range(20, 60);
      dv = $urandom_range(0, 6);
      write_cfg(hi, lo, dv, ($urandom_range(0, 4) != 0) ? 1 : 0,
                $urandom_range(0, 3), $urandom_range(0, 3));
      for (int k = 0; k < 400; k++) begin
        rssi_code = 7'($urandom_range(0, 127));
        if ($urandom_range(0, 150) == 0) rx_start = 1'b1;
        cyc();
        rx_start = 1'b0;
      end
    end

    // R8: receive entry restores defaults
    write_cfg(50, 40, 4, 0, 1, 1);
    rx_start = 1'b1;
    cyc();
    rx_start = 1'b0;
    chk("R8 rx_start lna", int'(lna_gain), 3);
    chk("R8 rx_start flt", int'(flt_gain), 2);
    chk("R8 rx_start cfg_err", int'(cfg_err), 0);
    rssi_code = 7'd50;
    repeat (12) cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule